// File: doc/BRIEF.md
# Amplifier Shutdown and Mute Sequencer

This block is the control state machine for a two-channel switching audio amplifier. It watches an active-low shutdown pin and an active-low mute pin. From them it decides when the modulator runs, when the power stage is told to switch, and when the output bridge is held in high impedance. Both control pins are asynchronous to the master clock. Each passes through a two-flop synchronizer before the state machine sees it.

When shutdown is released, the modulator starts at once. The bridge stays in high impedance for a fixed internal mute interval, counted in master-clock cycles, and the external mute cannot shorten it. Once that interval has expired and mute is high, the block waits a further start delay before the bridge switches. Pulling mute low keeps the bridge switching for a stop delay and then stops it. Pulling shutdown low stops everything and discards any progress through the internal mute interval. A fault-kill input puts the bridge in high impedance straight away, with no delay. All three intervals are parameters in master-clock cycles; their defaults correspond to 650 ms, 200 µs and 200 µs at 24.576 MHz. The recommended power-down order is mute first, then shutdown.

Top module: `amp_seq_ctrl`

## Requirements
- R1: While shutdown is low, and out of reset, `mod_en`=0, `stage_en`=0 and `bridge_hiz`=1. Mute changes in this state have no effect on the outputs.
- R2: When shutdown goes high, `mod_en` becomes 1 and `bridge_hiz` stays 1 with `stage_en`=0. `stage_en` is never 1 while `mod_en` is 0.
- R3: After shutdown is released, the bridge stays in high impedance for `MUTE_HOLD_CYC` cycles. Releasing mute earlier does not shorten this interval.
- R4: Switching (`stage_en`=1, `bridge_hiz`=0) begins exactly `ON_DLY_CYC` cycles after the later of two events: the end of the internal interval, or the synchronized release of mute. Switching never starts while the synchronized mute is low.
- R5: After the synchronized mute goes low, `stage_en` stays 1 for `OFF_DLY_CYC` cycles and then drops; `bridge_hiz` rises at the same time.
- R6: If mute returns high during the stop delay, switching continues with no output change. If mute drops during the start delay, switching does not start.
- R7: Shutdown going low in any state turns off all three controls together. A later release restarts the full internal mute interval.
- R8: `fault_kill`=1 forces `bridge_hiz`=1 combinationally, in the same cycle, bypassing the stop delay. It leaves `stage_en` and the sequence untouched, so the bridge resumes when the fault clears.
- R9: A change on `shdn_n` or `mute_n` affects the sequencer outputs at the third rising clock edge after it (two synchronizer flops plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Shutdown request, active low, asynchronous |
| mute_n | input | 1 | Mute request, active low, asynchronous |
| fault_kill | input | 1 | Fault kill, forces bridge to high impedance immediately |
| mod_en | output | 1 | Modulator enable |
| stage_en | output | 1 | Power-stage switching enable from the sequence |
| bridge_hiz | output | 1 | Output bridge high-impedance control |

## Verification
The embedded properties watch the following on every cycle:
- A low synchronized shutdown always leads to the off state on the next edge.
- The power stage never runs without the modulator.
- Switching never begins while the synchronized mute is low.
- The bridge is never enabled before the internal mute interval plus the start delay has elapsed since the modulator started; a counter measures this window.
- A running bridge always survives the first edge after mute falls.

Only the bench's scenarios can show the exact cycle at which each output edge lands. The same holds for three other behaviours: that early mute release does not shorten the interval, that short mute pulses in either delay leave the outputs unchanged, and that re-entering shutdown restarts the full interval.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_HOLD     = 3'd1,
    ST_IDLE     = 3'd2,
    ST_RAMP_ON  = 3'd3,
    ST_RUN      = 3'd4,
    ST_RAMP_OFF = 3'd5
  } seq_state_e;
endpackage

// File: rtl/amp_seq_sync.sv
module amp_seq_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/amp_seq_ctrl.sv
module amp_seq_ctrl
  import amp_seq_pkg::*;
#(
  parameter int MUTE_HOLD_CYC = 15974400,
  parameter int ON_DLY_CYC    = 4915,
  parameter int OFF_DLY_CYC   = 4915,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic mute_n,
  input  logic fault_kill,
  output logic mod_en,
  output logic stage_en,
  output logic bridge_hiz
);
  localparam int MAX_A = (MUTE_HOLD_CYC > ON_DLY_CYC) ? MUTE_HOLD_CYC : ON_DLY_CYC;
  localparam int MAX_D = (MAX_A > OFF_DLY_CYC) ? MAX_A : OFF_DLY_CYC;
  localparam int TW    = $clog2(MAX_D + 1);
  localparam int START_MIN = MUTE_HOLD_CYC + ON_DLY_CYC;
  localparam int SW    = $clog2(START_MIN + 1);
  localparam logic [TW-1:0] HOLD_V = TW'(MUTE_HOLD_CYC - 1);
  localparam logic [TW-1:0] ON_V   = TW'(ON_DLY_CYC - 1);
  localparam logic [TW-1:0] OFF_V  = TW'(OFF_DLY_CYC - 1);

  logic shdn_s, mute_s;
  logic t_load, t_zero;
  logic [TW-1:0] t_val;
  seq_state_e st, st_nxt;

  amp_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_shdn (
    .clk(clk), .rst_n(rst_n), .d(shdn_n), .q(shdn_s));
  amp_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mute (
    .clk(clk), .rst_n(rst_n), .d(mute_n), .q(mute_s));

  amp_seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

  always_comb begin
    st_nxt = st;
    t_load = 1'b0;
    t_val  = '0;
    if (!shdn_s) begin
      st_nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF: begin
          st_nxt = ST_HOLD; t_load = 1'b1; t_val = HOLD_V;
        end
        ST_HOLD: if (t_zero) begin
          if (mute_s) begin st_nxt = ST_RAMP_ON; t_load = 1'b1; t_val = ON_V; end
          else          st_nxt = ST_IDLE;
        end
        ST_IDLE: if (mute_s) begin
          st_nxt = ST_RAMP_ON; t_load = 1'b1; t_val = ON_V;
        end
        ST_RAMP_ON: begin
          if (!mute_s)     st_nxt = ST_IDLE;
          else if (t_zero) st_nxt = ST_RUN;
        end
        ST_RUN: if (!mute_s) begin
          st_nxt = ST_RAMP_OFF; t_load = 1'b1; t_val = OFF_V;
        end
        ST_RAMP_OFF: begin
          if (mute_s)      st_nxt = ST_RUN;
          else if (t_zero) st_nxt = ST_IDLE;
        end
        default: st_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nxt;
  end

  assign mod_en     = (st != ST_OFF);
  assign stage_en   = (st == ST_RUN) || (st == ST_RAMP_OFF);
  assign bridge_hiz = !stage_en || fault_kill;

  // Cycles since the modulator started, saturating; feeds the start-window check.
  logic [SW-1:0] since_on;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_on <= '0;
    else if (!mod_en)                    since_on <= '0;
    else if (since_on != SW'(START_MIN)) since_on <= since_on + 1'b1;
  end

  assert_off_on_shdn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_s |=> (!mod_en && !stage_en));

  assert_stage_needs_mod_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |-> mod_en);

  assert_hold_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en |-> (since_on >= SW'(START_MIN)));

  assert_no_start_muted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_en && !mute_s) |=> !stage_en);

  assert_stop_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && $fell(mute_s) && shdn_s) |=> stage_en);
endmodule

// File: tb/amp_seq_ctrl_tb_top.sv
module amp_seq_ctrl_tb_top;
  localparam int NH  = 40;
  localparam int NON = 10;
  localparam int NOF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, shdn_n = 1'b0, mute_n = 1'b0, fault_kill = 1'b0;
  logic mod_en, stage_en, bridge_hiz;

  amp_seq_ctrl #(.MUTE_HOLD_CYC(NH), .ON_DLY_CYC(NON), .OFF_DLY_CYC(NOF)) dut_i (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mute_n(mute_n),
    .fault_kill(fault_kill), .mod_en(mod_en), .stage_en(stage_en),
    .bridge_hiz(bridge_hiz));

  always #4 clk = ~clk;

  typedef struct { int cyc; logic [2:0] val; string req; } exp_t;
  exp_t exp_q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [2:0] prev;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every output change must match the next expected item.
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] cur;
      cur = {mod_en, stage_en, bridge_hiz};
      if (cur !== prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected change at cycle %0d: actual %b expected %b", cyc, cur, prev);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cyc != cyc || e.val !== cur) begin
            errors++;
            $display("FAIL %s: actual %b at cycle %0d expected %b at cycle %0d",
                     e.req, cur, cyc, e.val, e.cyc);
          end
        end
        prev = cur;
      end
    end
  end

  task automatic push(int c, logic [2:0] v, string r);
    exp_t e;
    e.cyc = c; e.val = v; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_vec(logic [2:0] v, string r);
    checks++;
    if ({mod_en, stage_en, bridge_hiz} !== v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", r, {mod_en, stage_en, bridge_hiz}, v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    int d, g;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check_vec(3'b001, "R1 reset state");
    prev = 3'b001;
    mon_on = 1'b1;
    // R1: mute activity while in shutdown has no effect
    mute_n = 1'b1; tick(4); mute_n = 1'b0; tick(4); mute_n = 1'b1;
    tick(10);
    check_vec(3'b001, "R1 mute ignored in shutdown");
    // R2 R3 R4 R9: release shutdown with mute already high
    d = cyc; shdn_n = 1'b1;
    push(d + 3, 3'b101, "R2 R9 modulator on");
    push(d + 3 + NH + NON, 3'b110, "R3 R4 switching start");
    tick(NH + NON + 10);
    // R5: stop delay
    d = cyc; mute_n = 1'b0;
    push(d + 3 + NOF, 3'b101, "R5 stop after delay");
    tick(NOF + 10);
    // R4: unmute from idle
    d = cyc; mute_n = 1'b1;
    push(d + 3 + NON, 3'b110, "R4 start delay");
    tick(NON + 10);
    // R6: short mute pulse inside stop delay
    mute_n = 1'b0; tick(5); mute_n = 1'b1; tick(30);
    check_vec(3'b110, "R6 mute glitch in stop delay");
    // R6: short unmute pulse inside start delay
    d = cyc; mute_n = 1'b0;
    push(d + 3 + NOF, 3'b101, "R5 stop after delay");
    tick(NOF + 10);
    mute_n = 1'b1; tick(4); mute_n = 1'b0; tick(30);
    check_vec(3'b101, "R6 unmute glitch in start delay");
    // R8: fault kill while running
    d = cyc; mute_n = 1'b1;
    push(d + 3 + NON, 3'b110, "R4 start delay");
    tick(NON + 10);
    d = cyc; fault_kill = 1'b1;
    push(d + 1, 3'b111, "R8 fault immediate hiz");
    tick(5);
    d = cyc; fault_kill = 1'b0;
    push(d + 1, 3'b110, "R8 resume after fault");
    tick(10);
    // R8: fault during stop delay
    d = cyc; mute_n = 1'b0;
    tick(2); fault_kill = 1'b1;
    push(d + 3, 3'b111, "R8 fault bypasses stop delay");
    push(d + 3 + NOF, 3'b101, "R5 R8 sequence continues under fault");
    tick(NOF + 8);
    fault_kill = 1'b0; tick(5);
    check_vec(3'b101, "R8 fault release while stopped");
    // R7: shutdown from running, then shutdown during hold
    d = cyc; mute_n = 1'b1;
    push(d + 3 + NON, 3'b110, "R4 start delay");
    tick(NON + 10);
    d = cyc; shdn_n = 1'b0;
    push(d + 3, 3'b001, "R7 shutdown from run");
    tick(10);
    d = cyc; shdn_n = 1'b1;
    push(d + 3, 3'b101, "R2 modulator on");
    tick(20);
    g = cyc; shdn_n = 1'b0;
    push(g + 3, 3'b001, "R7 shutdown during hold");
    tick(10);
    d = cyc; shdn_n = 1'b1;
    push(d + 3, 3'b101, "R2 modulator on");
    push(d + 3 + NH + NON, 3'b110, "R7 full interval restarted");
    tick(NH + NON + 10);
    // R3: early mute release does not shorten the internal interval
    d = cyc; mute_n = 1'b0;
    push(d + 3 + NOF, 3'b101, "R5 stop after delay");
    tick(NOF + 10);
    d = cyc; shdn_n = 1'b0;
    push(d + 3, 3'b001, "R7 shutdown from idle");
    tick(10);
    g = cyc; shdn_n = 1'b1;
    push(g + 3, 3'b101, "R2 modulator on");
    tick(10);
    mute_n = 1'b1;
    push(g + 3 + NH + NON, 3'b110, "R3 internal mute overrides early unmute");
    tick(NH + NON + 10);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing output events: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule